// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a segment:offset pair into a flat physical address for a processor that uses real-mode style segmented memory. It receives the four segment register values, the two base registers, the two index registers, the instruction pointer and a displacement, together with a description of which of these make up the operand's offset. From these it forms the effective offset and picks the segment. It then shifts the segment left by four bits and adds the offset. The sum is truncated, so addresses past the top of the space wrap around to address zero.

The offset is described by a base selection, an index selection and a displacement enable. Together these give direct, register-indirect, based, indexed and based-indexed operands. Because the offset is a plain sum, the order in which the parts are written does not matter. A fetch request ignores all of this and uses the code segment with the instruction pointer. By default the segment is the stack segment when BP takes part in the offset, and the data segment otherwise. An explicit override can replace that choice.

Requests that name both base registers or both index registers are flagged as illegal. Each request is accepted in one cycle, and its result appears one register stage later.

Top module: `seg_addr_gen`

## Requirements
- R1: For a legal request, `pa_o` equals (segment value × 2^SEG_SHIFT + effective offset) modulo 2^PA_W. With the default widths, segment FF59h and offset FFFFh give 0F58Fh.
- R2: When `fetch_i` is 1, the segment is CS (code 1) and the offset is `ip_i`. In that case base, index, displacement and override inputs have no effect, and `illegal_o` is 0.
- R3: For a non-fetch request, the effective offset `ea_o` is the sum modulo 2^OFF_W of the following parts: BX if `base_sel_i[0]`, BP if `base_sel_i[1]`, SI if `index_sel_i[0]`, DI if `index_sel_i[1]`, and `disp_i` if `disp_en_i`.
- R4: With no override, a non-fetch request uses SS (code 2) when `base_sel_i[1]` is 1. Otherwise it uses DS (code 3).
- R5: When `ovr_en_i` is 1 on a non-fetch request, the segment is the one coded on `ovr_seg_i` (ES=0, CS=1, SS=2, DS=3). This also holds when BP is used.
- R6: A non-fetch request with `base_sel_i`=3 (BX and BP) or `index_sel_i`=3 (SI and DI) sets `illegal_o`. It forces `pa_o` and `ea_o` to zero, and `valid_o` is still asserted for it.
- R7: `valid_o` in a cycle equals `valid_i` in the cycle before. A new request may be presented every cycle.
- R8: While reset is active, `valid_o`, `pa_o`, `ea_o`, `illegal_o` and `seg_used_o` are all zero.
- R9: In a cycle with `valid_i` low, `pa_o`, `ea_o`, `seg_used_o` and `illegal_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request present |
| fetch_i | input | 1 | Instruction fetch request (CS with IP) |
| base_sel_i | input | 2 | Bit 0 adds BX, bit 1 adds BP |
| index_sel_i | input | 2 | Bit 0 adds SI, bit 1 adds DI |
| disp_en_i | input | 1 | Add displacement |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment code: ES=0, CS=1, SS=2, DS=3 |
| cs_i | input | SEG_W | Code segment value |
| ds_i | input | SEG_W | Data segment value |
| ss_i | input | SEG_W | Stack segment value |
| es_i | input | SEG_W | Extra segment value |
| bx_i | input | OFF_W | Base register BX |
| bp_i | input | OFF_W | Base register BP |
| si_i | input | OFF_W | Index register SI |
| di_i | input | OFF_W | Index register DI |
| ip_i | input | OFF_W | Instruction pointer |
| disp_i | input | OFF_W | Displacement |
| valid_o | output | 1 | Result valid |
| pa_o | output | PA_W | Physical address |
| seg_used_o | output | 2 | Code of the segment actually used |
| ea_o | output | OFF_W | Effective offset |
| illegal_o | output | 1 | Illegal register combination |

## Verification
The bench builds the block with SEG_W=8, OFF_W=8 and SEG_SHIFT=4, which gives a 12-bit physical address. At that size, every pairing of segment value and displacement in direct mode can be applied: 65,536 vectors. That covers every carry into the upper nibble and every wrap past the top of the space. A second sweep covers every combination of fetch, base selection, index selection, displacement enable, override enable and override code. This exercises the default segment rules, every override and every illegal pairing, with register values that vary from vector to vector.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  localparam int unsigned NUM_TERMS = 5;
endpackage

// File: rtl/seg_addr_seg_mux.sv
module seg_addr_seg_mux
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic             fetch_i,
  input  logic             bp_used_i,
  input  logic             ovr_en_i,
  input  seg_e             ovr_seg_i,
  input  logic [SEG_W-1:0] cs_i,
  input  logic [SEG_W-1:0] ds_i,
  input  logic [SEG_W-1:0] ss_i,
  input  logic [SEG_W-1:0] es_i,
  output seg_e             seg_code_o,
  output logic [SEG_W-1:0] seg_val_o
);
  // fetch beats override, override beats default
  always_comb begin
    if (fetch_i)        seg_code_o = SEG_CS;
    else if (ovr_en_i)  seg_code_o = ovr_seg_i;
    else if (bp_used_i) seg_code_o = SEG_SS;
    else                seg_code_o = SEG_DS;
  end

  always_comb begin
    unique case (seg_code_o)
      SEG_ES:  seg_val_o = es_i;
      SEG_CS:  seg_val_o = cs_i;
      SEG_SS:  seg_val_o = ss_i;
      default: seg_val_o = ds_i;
    endcase
  end
endmodule

// File: rtl/seg_addr_offset.sv
module seg_addr_offset
  import seg_addr_pkg::*;
#(
  parameter int unsigned OFF_W = 16
) (
  input  logic             fetch_i,
  input  logic [1:0]       base_sel_i,
  input  logic [1:0]       index_sel_i,
  input  logic             disp_en_i,
  input  logic [OFF_W-1:0] bx_i,
  input  logic [OFF_W-1:0] bp_i,
  input  logic [OFF_W-1:0] si_i,
  input  logic [OFF_W-1:0] di_i,
  input  logic [OFF_W-1:0] ip_i,
  input  logic [OFF_W-1:0] disp_i,
  output logic [OFF_W-1:0] ea_o,
  output logic             illegal_o
);
  logic [OFF_W-1:0] src   [NUM_TERMS];
  logic             en    [NUM_TERMS];
  logic [OFF_W-1:0] term  [NUM_TERMS];
  logic [OFF_W-1:0] acc   [NUM_TERMS+1];

  assign src[0] = bx_i;   assign en[0] = base_sel_i[0];
  assign src[1] = bp_i;   assign en[1] = base_sel_i[1];
  assign src[2] = si_i;   assign en[2] = index_sel_i[0];
  assign src[3] = di_i;   assign en[3] = index_sel_i[1];
  assign src[4] = disp_i; assign en[4] = disp_en_i;

  assign acc[0] = '0;
  for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
    assign term[g]  = en[g] ? src[g] : '0;
    assign acc[g+1] = acc[g] + term[g]; // wraps modulo 2^OFF_W
  end

  logic pair_err;
  assign pair_err  = (&base_sel_i) | (&index_sel_i);
  assign illegal_o = !fetch_i && pair_err;
  assign ea_o      = fetch_i ? ip_i : acc[NUM_TERMS];
endmodule

// File: rtl/seg_addr_phys.sv
module seg_addr_phys #(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  parameter int unsigned PA_W      = SEG_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0] seg_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PA_W-1:0]  pa_o
);
  logic [PA_W-1:0] seg_sh;
  logic [PA_W-1:0] off_ext;

  assign seg_sh  = PA_W'({seg_i, {SEG_SHIFT{1'b0}}});
  assign off_ext = PA_W'(off_i);
  assign pa_o    = seg_sh + off_ext; // carry out dropped: top wraps to zero
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W     = 16,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned SEG_SHIFT = 4,
  localparam int unsigned PA_W     = SEG_W + SEG_SHIFT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fetch_i,
  input  logic [1:0]       base_sel_i,
  input  logic [1:0]       index_sel_i,
  input  logic             disp_en_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_seg_i,
  input  logic [SEG_W-1:0] cs_i,
  input  logic [SEG_W-1:0] ds_i,
  input  logic [SEG_W-1:0] ss_i,
  input  logic [SEG_W-1:0] es_i,
  input  logic [OFF_W-1:0] bx_i,
  input  logic [OFF_W-1:0] bp_i,
  input  logic [OFF_W-1:0] si_i,
  input  logic [OFF_W-1:0] di_i,
  input  logic [OFF_W-1:0] ip_i,
  input  logic [OFF_W-1:0] disp_i,
  output logic             valid_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [1:0]       seg_used_o,
  output logic [OFF_W-1:0] ea_o,
  output logic             illegal_o
);
  seg_e             seg_code;
  logic [SEG_W-1:0] seg_val;
  logic [OFF_W-1:0] ea;
  logic             illegal;
  logic [PA_W-1:0]  pa;

  seg_addr_seg_mux #(.SEG_W(SEG_W)) u_seg_mux (
    .fetch_i   (fetch_i),
    .bp_used_i (base_sel_i[1]),
    .ovr_en_i  (ovr_en_i),
    .ovr_seg_i (seg_e'(ovr_seg_i)),
    .cs_i      (cs_i),
    .ds_i      (ds_i),
    .ss_i      (ss_i),
    .es_i      (es_i),
    .seg_code_o(seg_code),
    .seg_val_o (seg_val)
  );

  seg_addr_offset #(.OFF_W(OFF_W)) u_offset (
    .fetch_i    (fetch_i),
    .base_sel_i (base_sel_i),
    .index_sel_i(index_sel_i),
    .disp_en_i  (disp_en_i),
    .bx_i       (bx_i),
    .bp_i       (bp_i),
    .si_i       (si_i),
    .di_i       (di_i),
    .ip_i       (ip_i),
    .disp_i     (disp_i),
    .ea_o       (ea),
    .illegal_o  (illegal)
  );

  seg_addr_phys #(
    .SEG_W    (SEG_W),
    .OFF_W    (OFF_W),
    .SEG_SHIFT(SEG_SHIFT),
    .PA_W     (PA_W)
  ) u_phys (
    .seg_i(seg_val),
    .off_i(ea),
    .pa_o (pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_o       <= '0;
      ea_o       <= '0;
      seg_used_o <= '0;
      illegal_o  <= 1'b0;
    end else if (valid_i) begin
      pa_o       <= illegal ? '0 : pa;
      ea_o       <= illegal ? '0 : ea;
      seg_used_o <= seg_code;
      illegal_o  <= illegal;
    end
  end

  // R7
  valid_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R7
  idle_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R6
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (pa_o == '0 && ea_o == '0));
  // R2
  fetch_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fetch_i) |=> (seg_used_o == SEG_CS && !illegal_o && ea_o == $past(ip_i)));
  // R5
  override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fetch_i && ovr_en_i) |=> (seg_used_o == $past(ovr_seg_i)));
  // R4
  bp_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fetch_i && !ovr_en_i && base_sel_i[1]) |=> (seg_used_o == SEG_SS));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pa_o) && $stable(ea_o) && $stable(seg_used_o)));
endmodule

// File: tb/seg_addr_gen_bench.sv
`timescale 1ns/1ps
module seg_addr_gen_bench;
  localparam int SW = 8;
  localparam int OW = 8;
  localparam int SH = 4;
  localparam int PW = SW + SH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          valid_i = 0, fetch_i = 0, disp_en_i = 0, ovr_en_i = 0;
  logic [1:0]    base_sel_i = 0, index_sel_i = 0, ovr_seg_i = 0;
  logic [SW-1:0] cs_i = 0, ds_i = 0, ss_i = 0, es_i = 0;
  logic [OW-1:0] bx_i = 0, bp_i = 0, si_i = 0, di_i = 0, ip_i = 0, disp_i = 0;
  logic          valid_o, illegal_o;
  logic [PW-1:0] pa_o;
  logic [1:0]    seg_used_o;
  logic [OW-1:0] ea_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  seg_addr_gen #(.SEG_W(SW), .OFF_W(OW), .SEG_SHIFT(SH)) u_seg_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .fetch_i(fetch_i),
    .base_sel_i(base_sel_i), .index_sel_i(index_sel_i), .disp_en_i(disp_en_i),
    .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i),
    .cs_i(cs_i), .ds_i(ds_i), .ss_i(ss_i), .es_i(es_i),
    .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i), .ip_i(ip_i), .disp_i(disp_i),
    .valid_o(valid_o), .pa_o(pa_o), .seg_used_o(seg_used_o), .ea_o(ea_o),
    .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive after a negedge, sample at the next negedge (one register stage)
  task automatic apply_vec(input string tag);
    int ea, seg, segv, pa, ill;
    ill = 0;
    if (fetch_i) begin
      ea = ip_i; seg = 1;
    end else begin
      ea = 0;
      if (base_sel_i[0]) ea += bx_i;
      if (base_sel_i[1]) ea += bp_i;
      if (index_sel_i[0]) ea += si_i;
      if (index_sel_i[1]) ea += di_i;
      if (disp_en_i) ea += disp_i;
      ea = ea % (1 << OW);
      if (ovr_en_i) seg = ovr_seg_i;
      else if (base_sel_i[1]) seg = 2;
      else seg = 3;
      ill = (base_sel_i == 2'd3 || index_sel_i == 2'd3) ? 1 : 0;
    end
    case (seg)
      0: segv = es_i;
      1: segv = cs_i;
      2: segv = ss_i;
      default: segv = ds_i;
    endcase
    pa = (segv * (1 << SH) + ea) % (1 << PW);
    if (ill != 0) begin pa = 0; ea = 0; end
    valid_i = 1'b1;
    @(negedge clk);
    n_vec++;
    if (valid_o !== 1'b1 || illegal_o !== ill[0] || seg_used_o !== seg[1:0] ||
        ea_o !== ea[OW-1:0] || pa_o !== pa[PW-1:0]) begin
      n_bad++;
      $display("FAIL %s v=%0b ill=%0b seg=%0d ea=%0h pa=%0h expected ill=%0d seg=%0d ea=%0h pa=%0h",
               tag, valid_o, illegal_o, seg_used_o, ea_o, pa_o, ill, seg, ea, pa);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 valid", valid_o, 0);
    chk("R8 pa", pa_o, 0);
    chk("R8 ea", ea_o, 0);
    chk("R8 seg", seg_used_o, 0);
    chk("R8 illegal", illegal_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6: every mode and override combination
    for (int k = 0; k < 512; k++) begin
      fetch_i     = k[0];
      base_sel_i  = k[2:1];
      index_sel_i = k[4:3];
      disp_en_i   = k[5];
      ovr_en_i    = k[6];
      ovr_seg_i   = k[8:7];
      cs_i = 8'(k * 7 + 3);   ds_i = 8'(k * 11 + 90);
      ss_i = 8'(k * 13 + 17); es_i = 8'(k * 5 + 200);
      bx_i = 8'(k * 29 + 1);  bp_i = 8'(k * 31 + 77);
      si_i = 8'(k * 37 + 5);  di_i = 8'(k * 41 + 150);
      ip_i = 8'(k * 43 + 9);  disp_i = 8'(k * 47 + 222);
      apply_vec(fetch_i ? "R2 fetch" : "R3/R4/R5/R6 mode");
    end

    // R1 exhaustive direct mode: every segment value with every displacement, incl. wrap
    fetch_i = 0; base_sel_i = 0; index_sel_i = 0; disp_en_i = 1; ovr_en_i = 0;
    for (int s = 0; s < 256; s++) begin
      for (int d = 0; d < 256; d++) begin
        ds_i = 8'(s); disp_i = 8'(d);
        apply_vec("R1 direct");
      end
    end

    // R1 top-of-space wrap: FF:FF -> FF0+FF = 10EF -> 0EF
    ds_i = 8'hFF; disp_i = 8'hFF;
    apply_vec("R1 wrap");
    chk("R1 wrap value", pa_o, 12'h0EF);

    // R9 idle cycle: change inputs, outputs hold; R7 valid drops
    valid_i = 1'b0; ds_i = 8'h12; disp_i = 8'h34;
    @(negedge clk);
    chk("R7 valid low", valid_o, 0);
    chk("R9 pa hold", pa_o, 12'h0EF);
    chk("R9 ea hold", ea_o, 8'hFF);
    chk("R9 seg hold", seg_used_o, 3);

    // R7 back-to-back after idle
    apply_vec("R7 resume");
    chk("R7 resume pa", pa_o, 12'h154);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule